// File: doc/BRIEF.md
# Coarse-Step Clock Trim Prescaler

This block turns a slow oscillator clock into two tick streams for a timekeeping circuit. The first is an intermediate tick, made by dividing the oscillator clock with a programmable reload value. The second is a one-second tick, made by counting intermediate ticks against a second reload value. It also drives a square-wave output that is a fixed power-of-two fraction of the oscillator. That output lets the oscillator error be measured on a frequency counter.

Oscillator error is trimmed in coarse steps. The block follows seconds and minutes inside a repeating correction cycle, which is 64 minutes long by default. The step count sets how many minutes at the start of each cycle are corrected: twice the step count. In each corrected minute, only the first second is changed. In speed-up mode that second loses two intermediate ticks. In slow-down mode it gains one intermediate tick. The step count and the direction are captured when a cycle begins, so software may change them at any time without disturbing a cycle that is already running.

Top module: `rtc_coarse_cal`

## Requirements
- R1: While reset is held, and on the first clock after it, the intermediate tick, the second tick and the square-wave output are all low.
- R2: The intermediate tick is a one-cycle pulse, repeating every `apre_reload_i + 1` oscillator cycles.
- R3: The square wave is bit `CAL_BIT` of the intermediate-prescaler phase. When `apre_reload_i + 1` is a multiple of 2^(CAL_BIT+1), it changes level exactly every 2^CAL_BIT oscillator cycles.
- R4: An uncorrected second lasts `spre_reload_i + 1` intermediate ticks.
- R5: With the direction input at 0 (speed-up), the first second of each minute whose index within the cycle is below 2×steps lasts `spre_reload_i − 1` intermediate ticks.
- R6: With the direction input at 1 (slow-down), that same second lasts `spre_reload_i + 2` intermediate ticks.
- R7: A step count of 0 leaves every second at its nominal length.
- R8: The step count and direction are sampled at reset and at the start of each cycle. A change in the middle of a cycle first takes effect in the next cycle.
- R9: When 2×steps is at least the number of minutes in a cycle, the first second of every minute is corrected.
- R10: Every second tick falls in the same cycle as an intermediate tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| apre_reload_i | input | APRE_W | Intermediate prescaler reload (period minus one); 6 or more for reliable trimming |
| spre_reload_i | input | SPRE_W | Second prescaler reload (ticks per second minus one); at least 2 |
| cal_steps_i | input | DC_W | Coarse correction step count; 0 disables correction |
| cal_slow_i | input | 1 | Direction: 0 shortens corrected seconds, 1 lengthens them |
| apre_tick_o | output | 1 | Intermediate tick pulse |
| sec_tick_o | output | 1 | One-second tick pulse |
| cal_clk_o | output | 1 | Square wave for measuring oscillator deviation |

## Verification
A wrong phase in the intermediate counter shows within one intermediate period: either the intermediate tick is displaced or the square wave breaks its regular toggle spacing. A fault in the second/minute tracker or in the captured configuration is quieter. It only shows when a corrected second ends with the wrong length, or an uncorrected second ends with a changed length. That can take up to a full correction cycle to appear at the ports. For this reason the bench shrinks the minute and cycle lengths and measures every second over two whole cycles.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic {
    CAL_SPEEDUP  = 1'b0,
    CAL_SLOWDOWN = 1'b1
  } cal_dir_e;

  // Reload value for one second: nominal, two ticks shorter, or one tick longer.
  function automatic int unsigned sec_load(input bit corr, input cal_dir_e dir,
                                           input int unsigned base);
    if (!corr) return base;
    if (dir == CAL_SLOWDOWN) return base + 1;
    return base - 2;
  endfunction

  // A minute of the cycle is corrected when its index is below twice the step count.
  function automatic bit minute_hit(input int unsigned minute, input int unsigned steps);
    return minute < 2 * steps;
  endfunction

endpackage

// File: rtl/rtc_apre_div.sv
module rtc_apre_div #(
  parameter int W       = 7,
  parameter int CAL_BIT = 5
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] reload_i,
  output logic         wrap_o,
  output logic         tick_o,
  output logic         cal_o
);
  logic [W-1:0] phase_q;

  assign wrap_o = (phase_q >= reload_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= '0;
      tick_o  <= 1'b0;
      cal_o   <= 1'b0;
    end else begin
      phase_q <= wrap_o ? '0 : phase_q + W'(1);
      tick_o  <= wrap_o;
      cal_o   <= phase_q[CAL_BIT];
    end
  end
endmodule

// File: rtl/rtc_spre_div.sv
module rtc_spre_div #(
  parameter int W = 8
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       step_i,
  input  logic [W:0] load_i,
  output logic       wrap_o,
  output logic       tick_o
);
  logic [W:0] left_q;

  assign wrap_o = step_i && (left_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      left_q <= load_i;
      tick_o <= 1'b0;
    end else begin
      if (step_i) left_q <= (left_q == '0) ? load_i : left_q - (W+1)'(1);
      tick_o <= wrap_o;
    end
  end
endmodule

// File: rtl/rtc_cal_tracker.sv
module rtc_cal_tracker
  import rtc_cal_pkg::*;
#(
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int DC_W          = 5,
  parameter int SPRE_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              adv_i,
  input  logic [DC_W-1:0]   steps_i,
  input  logic              slow_i,
  input  logic [SPRE_W-1:0] reload_i,
  output logic [SPRE_W:0]   load_o
);
  localparam int SEC_W = $clog2(SEC_PER_MIN);
  localparam int MIN_W = $clog2(MIN_PER_CYCLE);
  localparam int LD_W  = SPRE_W + 1;

  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q, nxt_min;
  logic [DC_W-1:0]  steps_q, steps_eff;
  cal_dir_e         dir_q, dir_eff;
  logic             last_sec, last_min, cyc_end, corr;

  always_comb begin
    last_sec  = (sec_q == SEC_W'(SEC_PER_MIN - 1));
    last_min  = (min_q == MIN_W'(MIN_PER_CYCLE - 1));
    cyc_end   = last_sec && last_min;
    nxt_min   = last_min ? '0 : min_q + MIN_W'(1);
    steps_eff = (rst_i || cyc_end) ? steps_i : steps_q;
    dir_eff   = (rst_i || cyc_end) ? cal_dir_e'(slow_i) : dir_q;
    if (rst_i) corr = minute_hit(0, int'(steps_eff));
    else       corr = last_sec && minute_hit(int'(nxt_min), int'(steps_eff));
    load_o    = LD_W'(sec_load(corr, dir_eff, int'(reload_i)));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sec_q   <= '0;
      min_q   <= '0;
      steps_q <= steps_i;
      dir_q   <= cal_dir_e'(slow_i);
    end else if (adv_i) begin
      sec_q <= last_sec ? '0 : sec_q + SEC_W'(1);
      if (last_sec) min_q <= nxt_min;
      if (cyc_end) begin
        steps_q <= steps_i;
        dir_q   <= cal_dir_e'(slow_i);
      end
    end
  end
endmodule

// File: rtl/rtc_coarse_cal.sv
module rtc_coarse_cal #(
  parameter int APRE_W        = 7,
  parameter int SPRE_W        = 8,
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int DC_W          = 5,
  parameter int CAL_BIT       = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [APRE_W-1:0] apre_reload_i,
  input  logic [SPRE_W-1:0] spre_reload_i,
  input  logic [DC_W-1:0]   cal_steps_i,
  input  logic              cal_slow_i,
  output logic              apre_tick_o,
  output logic              sec_tick_o,
  output logic              cal_clk_o
);
  logic            apre_wrap, sec_wrap;
  logic [SPRE_W:0] sec_load;

  rtc_apre_div #(.W(APRE_W), .CAL_BIT(CAL_BIT)) u_apre (
    .clk_i(clk_i), .rst_i(rst_i), .reload_i(apre_reload_i),
    .wrap_o(apre_wrap), .tick_o(apre_tick_o), .cal_o(cal_clk_o)
  );

  rtc_spre_div #(.W(SPRE_W)) u_spre (
    .clk_i(clk_i), .rst_i(rst_i), .step_i(apre_wrap), .load_i(sec_load),
    .wrap_o(sec_wrap), .tick_o(sec_tick_o)
  );

  rtc_cal_tracker #(
    .SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_CYCLE(MIN_PER_CYCLE),
    .DC_W(DC_W), .SPRE_W(SPRE_W)
  ) u_track (
    .clk_i(clk_i), .rst_i(rst_i), .adv_i(sec_wrap), .steps_i(cal_steps_i),
    .slow_i(cal_slow_i), .reload_i(spre_reload_i), .load_o(sec_load)
  );
endmodule

// File: rtl/rtc_coarse_cal_chk.sv
module rtc_coarse_cal_chk #(
  parameter int APRE_W = 7,
  parameter int SPRE_W = 8
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [APRE_W-1:0] apre_reload_i,
  input logic [SPRE_W-1:0] spre_reload_i,
  input logic              apre_tick_o,
  input logic              sec_tick_o
);
  logic [APRE_W:0] since_apre;
  logic [SPRE_W:0] ticks_in_sec;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      since_apre   <= '0;
      ticks_in_sec <= '0;
    end else begin
      since_apre   <= apre_tick_o ? (APRE_W+1)'(1) : since_apre + (APRE_W+1)'(1);
      ticks_in_sec <= sec_tick_o ? '0 : ticks_in_sec + (SPRE_W+1)'(apre_tick_o);
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk_i)
    rst_i |=> (!apre_tick_o && !sec_tick_o));

  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
    apre_tick_o |-> (since_apre == {1'b0, apre_reload_i} + (APRE_W+1)'(1)));

  a_r2_no_late_tick: assert property (@(posedge clk_i) disable iff (rst_i)
    since_apre <= {1'b0, apre_reload_i} + (APRE_W+1)'(1));

  a_r10_sec_on_apre: assert property (@(posedge clk_i) disable iff (rst_i)
    sec_tick_o |-> apre_tick_o);

  // R4, R5, R6: each completed second holds a nominal, shortened or lengthened tick count
  a_r4_sec_len_legal: assert property (@(posedge clk_i) disable iff (rst_i)
    sec_tick_o |-> (ticks_in_sec == {1'b0, spre_reload_i} ||
                    ticks_in_sec == {1'b0, spre_reload_i} - (SPRE_W+1)'(2) ||
                    ticks_in_sec == {1'b0, spre_reload_i} + (SPRE_W+1)'(1)));
endmodule

bind rtc_coarse_cal rtc_coarse_cal_chk #(.APRE_W(APRE_W), .SPRE_W(SPRE_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .apre_reload_i(apre_reload_i),
  .spre_reload_i(spre_reload_i), .apre_tick_o(apre_tick_o), .sec_tick_o(sec_tick_o)
);

// File: tb/test_rtc_coarse_cal.sv
module test_rtc_coarse_cal;
  localparam int AW = 4, SW = 3, SPM = 3, MPC = 8, DW = 3, CB = 2;
  localparam int A = 7, S = 5;
  localparam int SECS_PER_CYC = SPM * MPC;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] apre_rl = AW'(A);
  logic [SW-1:0] spre_rl = SW'(S);
  logic [DW-1:0] steps = '0;
  logic slow = 1'b0;
  logic apre_tick, sec_tick, cal_clk;

  always #4 clk = ~clk;

  rtc_coarse_cal #(.APRE_W(AW), .SPRE_W(SW), .SEC_PER_MIN(SPM), .MIN_PER_CYCLE(MPC),
                   .DC_W(DW), .CAL_BIT(CB)) i_rtc_coarse_cal (
    .clk_i(clk), .rst_i(rst), .apre_reload_i(apre_rl), .spre_reload_i(spre_rl),
    .cal_steps_i(steps), .cal_slow_i(slow), .apre_tick_o(apre_tick),
    .sec_tick_o(sec_tick), .cal_clk_o(cal_clk));

  int errs = 0, checks = 0;
  int cur_d0, cur_d1, cur_slow; bit cur_r8;
  bit mon_on = 0, seen_apre, seen_cal;
  int g, since_sec, since_apre, since_cal;
  logic cal_prev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int adj_of(input int gi);
    int m = (gi / SPM) % MPC;
    int d = ((gi / SECS_PER_CYC) == 0) ? cur_d0 : cur_d1;
    if ((gi % SPM) != 0 || m >= 2 * d) return 0;
    return cur_slow ? 1 : -2;
  endfunction

  function automatic string tag_of(input int gi);
    int d = ((gi / SECS_PER_CYC) == 0) ? cur_d0 : cur_d1;
    int a = adj_of(gi);
    if (cur_r8 && (gi / SECS_PER_CYC) == 1) return "R8";
    if (d == 0) return "R7";
    if (a != 0 && 2 * d >= MPC) return "R9";
    if (a > 0) return "R6";
    if (a < 0) return "R5";
    return "R4";
  endfunction

  always @(negedge clk) if (mon_on) begin
    since_sec++; since_apre++; since_cal++;
    if (apre_tick) begin
      if (seen_apre) chk(since_apre == A + 1, "R2", since_apre, A + 1);
      seen_apre = 1; since_apre = 0;
    end
    if (cal_clk !== cal_prev) begin
      if (seen_cal) chk(since_cal == (1 << CB), "R3", since_cal, 1 << CB);
      seen_cal = 1; since_cal = 0; cal_prev = cal_clk;
    end
    if (sec_tick) begin
      chk(apre_tick == 1'b1, "R10", int'(apre_tick), 1);
      if (g >= 1)
        chk(since_sec == (A + 1) * (S + 1 + adj_of(g)), tag_of(g), since_sec,
            (A + 1) * (S + 1 + adj_of(g)));
      g++; since_sec = 0;
    end
  end

  task automatic run(input int d0, input int d1, input int sl, input bit r8);
    mon_on = 0; rst = 1'b1;
    cur_d0 = d0; cur_d1 = d1; cur_slow = sl; cur_r8 = r8;
    steps = DW'(d0); slow = sl[0];
    repeat (3) @(negedge clk);
    chk(!apre_tick && !sec_tick && !cal_clk, "R1",
        int'({apre_tick, sec_tick, cal_clk}), 0);
    g = 0; since_sec = 0; since_apre = 0; since_cal = 0;
    seen_apre = 0; seen_cal = 0; cal_prev = 1'b0;
    mon_on = 1; rst = 1'b0;
    if (r8) begin
      while (g < 5) @(negedge clk);
      @(negedge clk);
      steps = DW'(d1); slow = ~slow;
    end
    while (g < 2 * SECS_PER_CYC + 1) @(negedge clk);
    mon_on = 0;
  endtask

  initial begin
    run(0, 0, 0, 0);   // R7, R4
    run(1, 1, 0, 0);   // R5
    run(1, 1, 1, 0);   // R6
    run(3, 3, 0, 0);   // R5
    run(3, 3, 1, 0);   // R6
    run(4, 4, 0, 0);   // R9
    run(7, 7, 1, 0);   // R9
    run(2, 0, 0, 1);   // R8: mid-cycle change waits for the next cycle
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule